// File: doc/BRIEF.md
# Latched Interval Timer with Continuous Mode

This block holds a pair of down-counting interval timers with an interrupt stage, programmed over a byte-wide register bus. The primary timer has a 16-bit count and a separate reload latch. Each of these is written one byte at a time. A mode field in the control register turns on continuous operation. In that mode, every expiry reloads the count from the latch and raises the primary timer's interrupt flag. The secondary timer only counts down and wraps.

Counting advances on a one-cycle `tick_en` strobe. The integrator derives that strobe from whatever prescaled clock the system uses. The interrupt stage keeps a flag and an enable for two sources: the primary timer, and an external shift-register event brought in on `sr_event`. It drives one level-sensitive interrupt line.

Register addresses: 0/1 primary count low/high, 2/3 latch low/high, 4/5 secondary count low/high, 6 control, 7 flags, 8 enables. Reads are combinational on `bus_addr`. Read side effects occur only when `bus_rd` is high.

Top module: `via_interval_timer`

## Requirements
- R1: A write to address 0 sets the primary count to {current high byte, written byte}. That cycle's tick is ignored.
- R2: A write to address 1 sets the primary count to {written byte, current low byte}. That cycle's tick is ignored. Reads of addresses 0 and 1 return bits 7:0 and bits 15:8 of the live count.
- R3: The latch is 17 bits wide. A write to address 2 replaces only bits 7:0. A write to address 3 replaces bits 15:8 and clears bit 16. Addresses 2 and 3 read back bits 7:0 and 15:8.
- R4: On each tick the primary count decrements. A tick at count 0 reloads latch−1 instead, or 0 when the latch is 0. The reload uses the latch value held before that cycle's edge.
- R5: A reload raises the primary timer flag only when control bits 7:6 equal 01 (continuous). In continuous mode the first flag comes count+1 ticks after a load, and later flags come every latch ticks. In any other mode the flag is never raised.
- R6: After reset the primary count is 0xFFFF, the latch is 0x10000 (so the first reload gives 0xFFFF), the secondary count is 0xFFFF, control and flags are 0, and the enables are 0b11.
- R7: `irq` is high exactly when flags AND enables is nonzero. Flag bit 1 is the primary timer and bit 0 is the shift-register source. Address 8 reads and writes the enables in bits 1:0. Address 7 reads flags in bits 1:0 and `irq` in bit 7.
- R8: A read of address 0 with `bus_rd` high clears flag bit 1. Writing 1s to address 7 clears the matching flags. A flag set in the same cycle as its clear ends up set.
- R9: The secondary count decrements on each tick and wraps from 0 to 0xFFFF. Addresses 4 and 5 follow the same byte-merge rule as R1 and R2, and a write there overrides that cycle's tick.
- R10: A one-cycle pulse on `sr_event` sets flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count strobe for both timers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| sr_event | input | 1 | Shift-register interrupt source pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can fall in the same cycle. One is the primary timer's expiry, which sets its flag. The other is the clear path: a read of the low count byte, or a write-1 to the flag register. The bench drives the count to zero and then issues a tick together with a low-byte read. A flag that remains set afterwards passes. Random traffic also lands counter writes on tick cycles and latch writes on reload cycles, and each result is compared against a cycle-by-cycle model of the requirements.

// File: rtl/via_tmr_pkg.sv
`timescale 1ns/1ps
package via_tmr_pkg;
   // register addresses (flag and enable layout is decoded by software)
   localparam int unsigned A_T1_LO  = 0;
   localparam int unsigned A_T1_HI  = 1;
   localparam int unsigned A_LAT_LO = 2;
   localparam int unsigned A_LAT_HI = 3;
   localparam int unsigned A_T2_LO  = 4;
   localparam int unsigned A_T2_HI  = 5;
   localparam int unsigned A_MODE   = 6;
   localparam int unsigned A_FLAGS  = 7;
   localparam int unsigned A_ENA    = 8;
   localparam int unsigned NUM_REGS = 9;

   // interrupt sources
   localparam int unsigned SRC_SR   = 0;
   localparam int unsigned SRC_T1   = 1;
   localparam int unsigned NUM_SRC  = 2;

   // mode field value that enables periodic reload events
   localparam logic [1:0] MODE_CONT = 2'b01;
endpackage

// File: rtl/via_bytecnt.sv
`timescale 1ns/1ps
module via_bytecnt #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  reload_val,
   output logic [CNT_W-1:0]  cnt,
   output logic              zero_tick
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_V = '1;

   logic [CNT_W-1:0] cnt_nxt;
   logic             wr_any;

   assign wr_any    = wr_lo | wr_hi;
   assign zero_tick = tick & ~wr_any & (cnt == '0);

   always_comb begin
      cnt_nxt = cnt;
      if (wr_lo)
         cnt_nxt = {cnt[CNT_W-1:DATA_W], wdata};
      else if (wr_hi)
         cnt_nxt = {wdata, cnt[DATA_W-1:0]};
      else if (tick) begin
         if (cnt == '0)
            cnt_nxt = reload_val;
         else
            cnt_nxt = cnt - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= RST_V;
      else        cnt <= cnt_nxt;
   end

   AST_LO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> cnt == {$past(cnt[CNT_W-1:DATA_W]), $past(wdata)}); // R1
   AST_HI_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> cnt == {$past(wdata), $past(cnt[DATA_W-1:0])}); // R2
   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_lo && !wr_hi && cnt != '0) |=> cnt == $past(cnt) - ONE); // R4
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      zero_tick |=> cnt == $past(reload_val)); // R4
endmodule

// File: rtl/via_reload_latch.sv
`timescale 1ns/1ps
module via_reload_latch #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  latch_rd,
   output logic [CNT_W-1:0]  reload_val
);
   localparam int unsigned LW = CNT_W + 1;
   localparam logic [LW-1:0] RST_V = LW'(1) << CNT_W;
   localparam logic [LW-1:0] ONE   = LW'(1);

   logic [LW-1:0] latch_q;
   logic [LW-1:0] latch_dec;

   always_ff @(posedge clk) begin
      if (!rst_n)
         latch_q <= RST_V;
      else if (wr_lo)
         latch_q <= {latch_q[LW-1:DATA_W], wdata};
      else if (wr_hi)
         latch_q <= {1'b0, wdata, latch_q[DATA_W-1:0]};
   end

   assign latch_dec  = latch_q - ONE;
   assign latch_rd   = latch_q[CNT_W-1:0];
   assign reload_val = (latch_q == '0) ? '0 : latch_dec[CNT_W-1:0];

   AST_LAT_LO_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> latch_q[LW-1:DATA_W] == $past(latch_q[LW-1:DATA_W])); // R3
   AST_LAT_HI_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (latch_q[DATA_W-1:0] == $past(latch_q[DATA_W-1:0]))
                            && !latch_q[LW-1]); // R3
endmodule

// File: rtl/via_irq_ctrl.sv
`timescale 1ns/1ps
module via_irq_ctrl #(
   parameter int unsigned NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic [NSRC-1:0] clr_vec,
   input  logic            en_wr,
   input  logic [NSRC-1:0] en_wdata,
   output logic [NSRC-1:0] flags,
   output logic [NSRC-1:0] enables,
   output logic            irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags   <= '0;
         enables <= '1;
      end else begin
         flags <= (flags & ~clr_vec) | set_vec;
         if (en_wr) enables <= en_wdata;
      end
   end

   assign irq = |(flags & enables);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> (flags & $past(set_vec)) == $past(set_vec)); // R8
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> (flags & $past(clr_vec & ~set_vec)) == '0); // R8
endmodule

// File: rtl/via_interval_timer.sv
`timescale 1ns/1ps
module via_interval_timer
   import via_tmr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 4,
   parameter bit          HAS_T2 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sr_event,
   output logic              irq
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_width
         $error("CNT_W must be twice DATA_W");
      end
      if (DATA_W < 4) begin : g_bad_data
         $error("DATA_W too narrow for flag readback");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("ADDR_W cannot reach every register");
      end
   endgenerate

   // address decode
   logic [NUM_REGS-1:0] wr_sel;
   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_dec
         assign wr_sel[gi] = bus_wr && (bus_addr == ADDR_W'(gi));
      end
   endgenerate

   logic rd_t1_lo;
   assign rd_t1_lo = bus_rd && (bus_addr == ADDR_W'(A_T1_LO));

   // control register
   logic [DATA_W-1:0] mode_q;
   logic              cont;
   always_ff @(posedge clk) begin
      if (!rst_n)              mode_q <= '0;
      else if (wr_sel[A_MODE]) mode_q <= bus_wdata;
   end
   assign cont = (mode_q[DATA_W-1 -: 2] == MODE_CONT);

   // primary timer
   logic [CNT_W-1:0] t1_cnt, t1_reload, lat_rd;
   logic             t1_zero;

   via_reload_latch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (wr_sel[A_LAT_LO]),
      .wr_hi      (wr_sel[A_LAT_HI]),
      .wdata      (bus_wdata),
      .latch_rd   (lat_rd),
      .reload_val (t1_reload)
   );

   via_bytecnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_t1 (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_en),
      .wr_lo      (wr_sel[A_T1_LO]),
      .wr_hi      (wr_sel[A_T1_HI]),
      .wdata      (bus_wdata),
      .reload_val (t1_reload),
      .cnt        (t1_cnt),
      .zero_tick  (t1_zero)
   );

   // secondary timer (optional)
   logic [CNT_W-1:0] t2_cnt;
   logic             t2_zero;
   generate
      if (HAS_T2) begin : g_t2
         via_bytecnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_t2 (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_en),
            .wr_lo      (wr_sel[A_T2_LO]),
            .wr_hi      (wr_sel[A_T2_HI]),
            .wdata      (bus_wdata),
            .reload_val ({CNT_W{1'b1}}),
            .cnt        (t2_cnt),
            .zero_tick  (t2_zero)
         );
      end else begin : g_no_t2
         assign t2_cnt  = '0;
         assign t2_zero = 1'b0;
      end
   endgenerate

   // interrupt stage
   logic [NUM_SRC-1:0] set_vec, clr_vec, flags, enables;
   logic               wr_flags;
   assign wr_flags         = wr_sel[A_FLAGS];
   assign set_vec[SRC_T1]  = t1_zero & cont;
   assign set_vec[SRC_SR]  = sr_event;
   assign clr_vec[SRC_T1]  = rd_t1_lo | (wr_flags & bus_wdata[SRC_T1]);
   assign clr_vec[SRC_SR]  = wr_flags & bus_wdata[SRC_SR];

   via_irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .en_wr    (wr_sel[A_ENA]),
      .en_wdata (bus_wdata[NUM_SRC-1:0]),
      .flags    (flags),
      .enables  (enables),
      .irq      (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(A_T1_LO):  bus_rdata = t1_cnt[DATA_W-1:0];
         ADDR_W'(A_T1_HI):  bus_rdata = t1_cnt[CNT_W-1 -: HI_W];
         ADDR_W'(A_LAT_LO): bus_rdata = lat_rd[DATA_W-1:0];
         ADDR_W'(A_LAT_HI): bus_rdata = lat_rd[CNT_W-1 -: HI_W];
         ADDR_W'(A_T2_LO):  bus_rdata = t2_cnt[DATA_W-1:0];
         ADDR_W'(A_T2_HI):  bus_rdata = t2_cnt[CNT_W-1 -: HI_W];
         ADDR_W'(A_MODE):   bus_rdata = mode_q;
         ADDR_W'(A_FLAGS):  bus_rdata = {irq, {(DATA_W-1-NUM_SRC){1'b0}}, flags};
         ADDR_W'(A_ENA):    bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, enables};
         default:           bus_rdata = '0;
      endcase
   end

   AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cont && !flags[SRC_T1]) |=> !flags[SRC_T1]); // R5
   AST_T2_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      t2_zero |=> t2_cnt == {CNT_W{1'b1}}); // R9
   AST_SR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      sr_event |=> flags[SRC_SR]); // R10
endmodule

// File: tb/via_interval_timer_tb.sv
`timescale 1ns/1ps
module via_interval_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, sr_event = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // model state
   logic [15:0] m_t1, m_t2;
   logic [16:0] m_latch;
   logic [7:0]  m_mode;
   logic [1:0]  m_flags, m_en;

   always #2.5 clk = ~clk;

   via_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sr_event(sr_event), .irq(irq)
   );

   function automatic logic m_irq();
      return |(m_flags & m_en);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [3:0] a);
      case (a)
         4'd0: return m_t1[7:0];
         4'd1: return m_t1[15:8];
         4'd2: return m_latch[7:0];
         4'd3: return m_latch[15:8];
         4'd4: return m_t2[7:0];
         4'd5: return m_t2[15:8];
         4'd6: return m_mode;
         4'd7: return {m_irq(), 5'b0, m_flags};
         4'd8: return {6'b0, m_en};
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0, 4'd1: return "R1/R2";
         4'd2, 4'd3: return "R3";
         4'd4, 4'd5: return "R9";
         4'd7:       return "R8";
         default:    return "R7";
      endcase
   endfunction

   task automatic cyc(input bit wr, input bit rd, input logic [3:0] a,
                      input logic [7:0] d, input bit tk, input bit se);
      logic [15:0] n_t1, n_t2, rel;
      logic [16:0] n_latch;
      logic [7:0]  n_mode;
      logic [1:0]  n_flags, n_en, setv, clrv;
      logic        evt;
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_en = tk; sr_event = se;
      rel = (m_latch == 17'd0) ? 16'd0 : 16'(m_latch - 17'd1);
      evt = tk && !(wr && (a == 4'd0 || a == 4'd1)) && (m_t1 == 16'd0);
      n_t1 = m_t1;
      if (wr && a == 4'd0)      n_t1 = {m_t1[15:8], d};
      else if (wr && a == 4'd1) n_t1 = {d, m_t1[7:0]};
      else if (tk)              n_t1 = (m_t1 == 16'd0) ? rel : m_t1 - 16'd1;
      n_t2 = m_t2;
      if (wr && a == 4'd4)      n_t2 = {m_t2[15:8], d};
      else if (wr && a == 4'd5) n_t2 = {d, m_t2[7:0]};
      else if (tk)              n_t2 = m_t2 - 16'd1;
      n_latch = m_latch;
      if (wr && a == 4'd2)      n_latch = {m_latch[16:8], d};
      else if (wr && a == 4'd3) n_latch = {1'b0, d, m_latch[7:0]};
      n_mode = (wr && a == 4'd6) ? d : m_mode;
      setv = {evt && (m_mode[7:6] == 2'b01), se};
      clrv = {(rd && a == 4'd0) || (wr && a == 4'd7 && d[1]), wr && a == 4'd7 && d[0]};
      n_flags = (m_flags & ~clrv) | setv;
      n_en = (wr && a == 4'd8) ? d[1:0] : m_en;
      @(posedge clk);
      m_t1 = n_t1; m_t2 = n_t2; m_latch = n_latch; m_mode = n_mode;
      m_flags = n_flags; m_en = n_en;
      #1;
      bus_wr = 1'b0; bus_rd = 1'b0; tick_en = 1'b0; sr_event = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cyc(1'b1, 1'b0, a, d, 1'b0, 1'b0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
   endtask

   task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a;
      #0.2;
      checks++;
      if (bus_rdata !== exp) begin
         fails++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      checks++;
      if (irq !== exp) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      m_t1 = 16'hFFFF; m_t2 = 16'hFFFF; m_latch = 17'h10000;
      m_mode = 8'h00; m_flags = 2'b00; m_en = 2'b11;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R6 reset state
      chk(4'd0, 8'hFF, "R6"); chk(4'd1, 8'hFF, "R6"); chk(4'd3, 8'h00, "R6");
      chk(4'd8, 8'h03, "R6"); chk(4'd7, 8'h00, "R6");
      chk_irq(1'b0, "R6");

      // R1, R2 byte merge; R11-style live high byte read (R2)
      wr(4'd0, 8'h00);
      chk(4'd1, 8'hFF, "R1"); chk(4'd0, 8'h00, "R1");
      wr(4'd1, 8'h01);
      chk(4'd1, 8'h01, "R2"); chk(4'd0, 8'h00, "R2");
      ticks(1);
      chk(4'd1, 8'h00, "R2"); chk(4'd0, 8'hFF, "R4");
      chk(4'd7, 8'h00, "R5");

      // R4/R5 reset latch gives 0xFFFF reload in continuous mode
      wr(4'd1, 8'h00); wr(4'd0, 8'h00); wr(4'd6, 8'h40);
      ticks(1);
      chk(4'd0, 8'hFF, "R4"); chk(4'd1, 8'hFF, "R6");
      chk(4'd7, 8'h82, "R5"); chk_irq(1'b1, "R7");
      wr(4'd7, 8'h02);
      chk(4'd7, 8'h00, "R8"); chk_irq(1'b0, "R8");

      // R3 latch bytes, R5 first event count+1, then latch period
      wr(4'd2, 8'h05); wr(4'd3, 8'h00);
      chk(4'd2, 8'h05, "R3"); chk(4'd3, 8'h00, "R3");
      wr(4'd0, 8'h03); wr(4'd1, 8'h00);
      ticks(3);
      chk(4'd0, 8'h00, "R4"); chk(4'd7, 8'h00, "R5");
      ticks(1);
      chk(4'd0, 8'h04, "R4"); chk(4'd7, 8'h82, "R5");
      cyc(1'b0, 1'b1, 4'd0, 8'h00, 1'b0, 1'b0);
      chk(4'd7, 8'h00, "R8");
      ticks(4);
      chk(4'd7, 8'h00, "R5");
      ticks(1);
      chk(4'd7, 8'h82, "R5");
      cyc(1'b0, 1'b1, 4'd0, 8'h00, 1'b0, 1'b0);

      // R8 set beats clear in the same cycle
      ticks(4);
      chk(4'd0, 8'h00, "R8"); chk(4'd7, 8'h00, "R8");
      cyc(1'b0, 1'b1, 4'd0, 8'h00, 1'b1, 1'b0);
      chk(4'd7, 8'h82, "R8");

      // R7 enable gating
      wr(4'd8, 8'h00);
      chk_irq(1'b0, "R7"); chk(4'd7, 8'h02, "R7");
      wr(4'd8, 8'h02);
      chk_irq(1'b1, "R7");
      wr(4'd7, 8'h02);
      chk_irq(1'b0, "R8");

      // R5 non-continuous mode: reload but no flag
      wr(4'd6, 8'h80); wr(4'd0, 8'h00); wr(4'd1, 8'h00);
      ticks(1);
      chk(4'd0, 8'h04, "R4"); chk(4'd7, 8'h00, "R5");

      // R9 secondary timer wrap, write beats tick
      wr(4'd4, 8'h00); wr(4'd5, 8'h00);
      ticks(1);
      chk(4'd4, 8'hFF, "R9"); chk(4'd5, 8'hFF, "R9");
      cyc(1'b1, 1'b0, 4'd4, 8'h10, 1'b1, 1'b0);
      chk(4'd4, 8'h10, "R9"); chk(4'd5, 8'hFF, "R9");

      // R10 shift-register source, gated by enable bit 0 (R7)
      cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1);
      chk(4'd7, 8'h01, "R10"); chk_irq(1'b0, "R7");
      wr(4'd8, 8'h03);
      chk_irq(1'b1, "R10");
      wr(4'd7, 8'h01);
      chk_irq(1'b0, "R8");

      // constrained random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int op;
         logic [3:0] ra;
         logic [7:0] d;
         bit tk, se, w, r;
         op = int'($urandom % 16);
         tk = ($urandom % 4) != 0;
         se = ($urandom % 16) == 0;
         w = 1'b0; r = 1'b0; ra = 4'd0; d = 8'($urandom);
         case (op)
            0, 1: begin w = 1'b1; ra = 4'd0; d = 8'($urandom % 12); end
            2:    begin w = 1'b1; ra = 4'd1; d = 8'($urandom % 2); end
            3:    begin w = 1'b1; ra = 4'd2; d = 8'($urandom % 10); end
            4:    begin w = 1'b1; ra = 4'd3; d = 8'($urandom % 2); end
            5:    begin w = 1'b1; ra = 4'd4; end
            6:    begin w = 1'b1; ra = 4'd5; end
            7:    begin w = 1'b1; ra = 4'd6;
                     case ($urandom % 4)
                        0: d = 8'h40; 1: d = 8'h00; 2: d = 8'hC0; default: d = 8'h7F;
                     endcase
                  end
            8:    begin w = 1'b1; ra = 4'd7; end
            9:    begin w = 1'b1; ra = 4'd8; end
            10, 11: begin r = 1'b1; ra = 4'd0; end
            default: ;
         endcase
         cyc(w, r, ra, d, tk, se);
         chk_irq(m_irq(), "R7");
         begin
            logic [3:0] pa;
            pa = 4'($urandom % 9);
            chk(pa, exp_rd(pa), tag_of(pa));
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule